// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator

This block decides when the alarm of a real-time clock fires. Each time the time-of-day counters move forward by one second, it compares the new hours, minutes and seconds bytes with three alarm bytes. When all three fields agree, it sets a sticky alarm flag. The comparison uses the bytes exactly as stored, so it works the same in BCD and in binary data mode. No conversion takes place, because both sides are held in the same encoding.

Any alarm byte whose two top bits are both 1 is a wildcard and matches any time value. With the right mix of wildcards, one comparator can fire once per day, once per hour, once per minute or on every second. Software can also rewrite the alarm bytes between seconds to get alarms on back-to-back seconds.

While the clock is held for setting, matching stops. The flag stays set until the status-clear strobe arrives.

Top module: `rtc_alarm_match`

## Requirements
- R1: While rst_n is low, alarm_flag is 0 on the next clock edge.
- R2: When second_tick is 1, hold_set is 0 and all three fields match, alarm_flag is 1 one cycle later. A field matches when the alarm byte equals the time byte in all 8 bits.
- R3: If any one non-wildcard field differs at a tick, that tick leaves alarm_flag unchanged.
- R4: An alarm byte with bits [7:6] = 2'b11 (0xC0 to 0xFF) is a wildcard and matches every time value. With all three fields wildcarded, every tick sets the flag.
- R5: In a cycle with second_tick = 0, no comparison happens, even when the fields match.
- R6: While hold_set is 1, a tick sets nothing, even when the fields match.
- R7: When flag_clear is 1 and the flag is not being set, alarm_flag is 0 one cycle later. With neither a set nor a clear, the flag keeps its value.
- R8: A set and a clear in the same cycle leave alarm_flag at 1, so no alarm is lost.
- R9: Bytes are compared without any decoding. A time byte of 8'h10 (BCD ten) does not match an alarm byte of 8'd10 (binary ten).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| second_tick | input | 1 | One-cycle strobe; the time bytes already show the new second |
| hold_set | input | 1 | Clock-setting hold; suspends matching |
| flag_clear | input | 1 | One-cycle strobe that clears the flag |
| time_sec | input | 8 | Current seconds byte |
| time_min | input | 8 | Current minutes byte |
| time_hr | input | 8 | Current hours byte |
| alarm_sec | input | 8 | Seconds alarm byte; wildcard if bits [7:6] = 11 |
| alarm_min | input | 8 | Minutes alarm byte; wildcard if bits [7:6] = 11 |
| alarm_hr | input | 8 | Hours alarm byte; wildcard if bits [7:6] = 11 |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
Only one register lies between the inputs and alarm_flag. The effect of a tick, a hold or a clear therefore shows exactly one rising edge after the cycle in which it was driven. The bench drives inputs on the falling edge and updates its model of the flag for that cycle. It then compares alarm_flag 1 ns after the following rising edge, so every result is read in the one cycle where it is due. Directed cases cover each requirement. Random cases draw time and alarm bytes from a small pool so that matches, wildcards and clear collisions occur often.

// File: rtl/rtc_alarm_pkg.sv
// Package rtc_alarm_pkg: shared sizes and the wildcard rule for the alarm comparator.
// Assumes byte-wide time fields whose top two bits are unused by any valid time value.
package rtc_alarm_pkg;
    localparam int FIELD_W  = 8;
    localparam int N_FIELDS = 3;
    localparam int WILD_W   = 2;

    // A field is a wildcard when its top WILD_W bits are all set.
    function automatic logic is_wild(input logic [FIELD_W-1:0] b);
        return &b[FIELD_W-1 -: WILD_W];
    endfunction
endpackage

// File: rtl/alarm_field_cmp.sv
// Module alarm_field_cmp: match test for one time field against one alarm byte.
// Assumes both bytes use the same encoding (BCD or binary); no decoding is done.
module alarm_field_cmp
    import rtc_alarm_pkg::*;
(
    input  logic [FIELD_W-1:0] cur_b,
    input  logic [FIELD_W-1:0] alm_b,
    output logic               hit
);
    // Purpose: the field hits on a wildcard or on exact byte equality.
    always_comb begin
        hit = is_wild(alm_b) || (cur_b == alm_b);
    end
endmodule

// File: rtl/alarm_match_all.sv
// Module alarm_match_all: combines the per-field tests into one match signal.
// Assumes the fields come in as packed arrays with N_FIELDS entries.
module alarm_match_all
    import rtc_alarm_pkg::*;
(
    input  logic [N_FIELDS-1:0][FIELD_W-1:0] cur_f,
    input  logic [N_FIELDS-1:0][FIELD_W-1:0] alm_f,
    output logic                             all_hit
);
    logic [N_FIELDS-1:0] hits;

    for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
        alarm_field_cmp u_cmp (
            .cur_b (cur_f[g]),
            .alm_b (alm_f[g]),
            .hit   (hits[g])
        );
    end

    // Purpose: all fields must hit.
    always_comb begin
        all_hit = &hits;
    end
endmodule

// File: rtl/alarm_flag_reg.sv
// Module alarm_flag_reg: sticky flag register; a set wins over a clear.
// Assumes set_req and clr_req are single-cycle qualified requests.
module alarm_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag_q
);
    // Purpose: hold the flag; a set has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_req) flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end
endmodule

// File: rtl/rtc_alarm_match.sv
// Module rtc_alarm_match: compares the time with the alarm bytes on each
// second advance and raises a sticky alarm flag.
// Assumes the time bytes already show the new second during the tick cycle.
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               second_tick,
    input  logic               hold_set,
    input  logic               flag_clear,
    input  logic [FIELD_W-1:0] time_sec,
    input  logic [FIELD_W-1:0] time_min,
    input  logic [FIELD_W-1:0] time_hr,
    input  logic [FIELD_W-1:0] alarm_sec,
    input  logic [FIELD_W-1:0] alarm_min,
    input  logic [FIELD_W-1:0] alarm_hr,
    output logic               alarm_flag
);
    logic [N_FIELDS-1:0][FIELD_W-1:0] cur_f;
    logic [N_FIELDS-1:0][FIELD_W-1:0] alm_f;
    logic                             match_w;
    logic                             fire_w;

    // Purpose: pack the fields so the comparators can be generated.
    always_comb begin
        cur_f = {time_hr, time_min, time_sec};
        alm_f = {alarm_hr, alarm_min, alarm_sec};
    end

    alarm_match_all u_match (
        .cur_f   (cur_f),
        .alm_f   (alm_f),
        .all_hit (match_w)
    );

    // Purpose: qualify the match with the tick; the hold blocks it.
    always_comb begin
        fire_w = second_tick && !hold_set && match_w;
    end

    alarm_flag_reg u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (fire_w),
        .clr_req (flag_clear),
        .flag_q  (alarm_flag)
    );
endmodule

// File: rtl/rtc_alarm_match_chk.sv
// Module rtc_alarm_match_chk: port-level temporal checks for rtc_alarm_match.
// Assumes it sees only the top-level ports.
module rtc_alarm_match_chk
    import rtc_alarm_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               second_tick,
    input logic               hold_set,
    input logic               flag_clear,
    input logic [FIELD_W-1:0] time_sec,
    input logic [FIELD_W-1:0] time_min,
    input logic [FIELD_W-1:0] time_hr,
    input logic [FIELD_W-1:0] alarm_sec,
    input logic [FIELD_W-1:0] alarm_min,
    input logic [FIELD_W-1:0] alarm_hr,
    input logic               alarm_flag
);
    logic fld_ok;

    // Purpose: independent view of the match condition.
    always_comb begin
        fld_ok = (is_wild(alarm_sec) || time_sec == alarm_sec)
              && (is_wild(alarm_min) || time_min == alarm_min)
              && (is_wild(alarm_hr)  || time_hr  == alarm_hr);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> !alarm_flag); // R1
    AST_TICK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (second_tick && !hold_set && fld_ok) |=> alarm_flag); // R2
    AST_IDLE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_flag && (!second_tick || hold_set)) |=> !alarm_flag); // R5
    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_set && !alarm_flag) |=> !alarm_flag); // R6
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clear && !(second_tick && !hold_set && fld_ok)) |=> !alarm_flag); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !flag_clear) |=> alarm_flag); // R7
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (.*);

// File: tb/sim_rtc_alarm_match.sv
module sim_rtc_alarm_match;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       second_tick = 1'b0, hold_set = 1'b0, flag_clear = 1'b0;
    logic [7:0] time_sec = '0, time_min = '0, time_hr = '0;
    logic [7:0] alarm_sec = '0, alarm_min = '0, alarm_hr = '0;
    logic       alarm_flag;
    logic       exp_flag = 1'b0;
    int         n_vec = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    rtc_alarm_match u0 (.*);

    function automatic bit fmatch(input logic [7:0] c, input logic [7:0] a);
        return (a[7:6] == 2'b11) || (c == a);
    endfunction

    function automatic bit all_match();
        return fmatch(time_sec, alarm_sec) && fmatch(time_min, alarm_min)
            && fmatch(time_hr, alarm_hr);
    endfunction

    function automatic logic next_flag(input logic cur);
        if (!rst_n) return 1'b0;
        if (second_tick && !hold_set && all_match()) return 1'b1;
        if (flag_clear) return 1'b0;
        return cur;
    endfunction

    // drive one cycle at negedge, compare one ns after the next posedge
    task automatic step(input logic tk, input logic hd, input logic cl,
                        input logic [7:0] ch, input logic [7:0] cm, input logic [7:0] cs,
                        input logic [7:0] ah, input logic [7:0] am, input logic [7:0] as_,
                        input string tag);
        @(negedge clk);
        second_tick = tk; hold_set = hd; flag_clear = cl;
        time_hr = ch; time_min = cm; time_sec = cs;
        alarm_hr = ah; alarm_min = am; alarm_sec = as_;
        exp_flag = next_flag(exp_flag);
        @(posedge clk); #1;
        n_vec++;
        if (alarm_flag !== exp_flag) begin
            n_bad++;
            $display("FAIL %s: alarm_flag=%b expected=%b", tag, alarm_flag, exp_flag);
        end
    endtask

    task automatic clr_cycle(input string tag);
        step(0, 0, 1, 0, 0, 0, 8'h55, 8'h55, 8'h55, tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1 reset state
        step(1, 0, 0, 8'h09, 0, 0, 8'h09, 0, 0, "R1");
        step(1, 0, 0, 8'h09, 0, 0, 8'h09, 0, 0, "R1");
        rst_n = 1'b1;
        // R3 seconds differ
        step(1, 0, 0, 8'h09, 8'h00, 8'h01, 8'h09, 8'h00, 8'h02, "R3");
        // R3 hours differ
        step(1, 0, 0, 8'h08, 8'h00, 8'h02, 8'h09, 8'h00, 8'h02, "R3");
        // R5 match but no tick
        step(0, 0, 0, 8'h09, 8'h00, 8'h02, 8'h09, 8'h00, 8'h02, "R5");
        // R6 match with hold
        step(1, 1, 0, 8'h09, 8'h00, 8'h02, 8'h09, 8'h00, 8'h02, "R6");
        // R2 exact match
        step(1, 0, 0, 8'h09, 8'h00, 8'h02, 8'h09, 8'h00, 8'h02, "R2");
        step(0, 0, 0, 0, 0, 0, 8'h55, 8'h55, 8'h55, "R7");
        clr_cycle("R7");
        // R2 back-to-back seconds with rewritten alarm
        for (int s = 3; s <= 5; s++) begin
            step(1, 0, 0, 8'h09, 8'h00, 8'(s), 8'h09, 8'h00, 8'(s), "R2");
            clr_cycle("R7");
        end
        // R9 BCD ten vs binary ten
        step(1, 0, 0, 8'h09, 8'h00, 8'h10, 8'h09, 8'h00, 8'd10, "R9");
        // R4 wildcard seconds over several seconds
        for (int s = 6; s <= 8; s++) begin
            step(1, 0, 0, 8'h09, 8'h00, 8'(s), 8'h09, 8'h00, 8'hC0, "R4");
            clr_cycle("R4");
        end
        // R4 all wildcards, varied time and wildcard values
        step(1, 0, 0, 8'h23, 8'h59, 8'h59, 8'hFF, 8'hC7, 8'hC0, "R4");
        clr_cycle("R4");
        // R4 wildcard minutes, seconds mismatch stays clear
        step(1, 0, 0, 8'h09, 8'h31, 8'h07, 8'h09, 8'hC0, 8'h08, "R4");
        // R8 set and clear together
        step(1, 0, 1, 8'h01, 8'h02, 8'h03, 8'h01, 8'h02, 8'h03, "R8");
        step(0, 0, 0, 0, 0, 0, 8'h55, 8'h55, 8'h55, "R7");
        clr_cycle("R7");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] pool [4];
            logic tk, hd, cl;
            logic [7:0] v [6];
            string tg;
            pool[0] = 8'h00; pool[1] = 8'h10; pool[2] = 8'd10; pool[3] = 8'h59;
            tk = ($urandom % 3) != 0;
            hd = ($urandom % 6) == 0;
            cl = ($urandom % 4) == 0;
            for (int k = 0; k < 6; k++) begin
                v[k] = pool[$urandom % 4];
                if (k >= 3 && ($urandom % 4) == 0) v[k] = 8'hC0 | 8'($urandom % 64);
            end
            if (k_rst(i)) rst_n = 1'b0; else rst_n = 1'b1;
            time_hr = v[0]; time_min = v[1]; time_sec = v[2];
            alarm_hr = v[3]; alarm_min = v[4]; alarm_sec = v[5];
            if (!rst_n) tg = "R1";
            else if (tk && hd) tg = "R6";
            else if (tk && all_match() && cl) tg = "R8";
            else if (tk && all_match()) tg = "R2";
            else if (cl) tg = "R7";
            else if (tk) tg = "R3";
            else tg = "R5";
            step(tk, hd, cl, v[0], v[1], v[2], v[3], v[4], v[5], tg);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    function automatic bit k_rst(input int i);
        return (i % 500) == 499;
    endfunction
endmodule